// File: doc/BRIEF.md
# SIR Baud Rate Generator

This block produces the timing strobes for a slow-rate infrared UART running from a fixed 48 MHz clock. A fixed divide-by-26 prescaler feeds a programmable divisor that divides by (N+1). N is a 6-bit count held in a 16-bit register. The divisor output is a one-cycle oversampling strobe at 16 times the bit rate. A second strobe marks every sixteenth oversampling strobe and gives the bit rate. The bit rate is therefore 48 MHz / 26 / (N+1) / 16.

Software writes the count register only while the link runs at the slow infrared rate. Each write restarts the prescaler, the divisor and the bit phase, so the first period after the write is a full period at the new rate. The reset count is 11, which is the 9600 bit/s setting (48000000/26/16/9600 - 1, truncated).

Top module: `sir_baud_gen`

## Requirements
- R1: While reset is asserted, both strobes are 0 and the count register reads 0x000B.
- R2: With count N, `ovs_stb_o` is high for exactly one cycle every 26*(N+1) clock cycles. The first pulse appears 26*(N+1) cycles after the last reload.
- R3: A count of 0 gives the fastest rate, with one oversampling pulse every 26 cycles.
- R4: `bit_stb_o` pulses together with every sixteenth `ovs_stb_o` pulse after a reload, and never at any other time.
- R5: A write to the count register clears the prescaler, divisor and bit phase on the write edge, even in the middle of a period and even if the same value is rewritten. Neither strobe is high in the cycle after the write.
- R6: The count register takes `reg_wdata_i[5:0]`. `reg_rdata_o[5:0]` returns the count and `reg_rdata_o[15:6]` always reads 0, whatever was written to those bits.
- R7: The largest count, 63, gives an oversampling period of 1664 cycles and a bit period of 26624 cycles.
- R8: Out of reset with no write, the bit period is 4992 cycles, which is the 9600 bit/s setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 48 MHz reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Write strobe for the count register |
| reg_wdata_i | input | 16 | Write data; only bits 5:0 are kept |
| reg_rdata_o | output | 16 | Count register read value |
| ovs_stb_o | output | 1 | One-cycle strobe at 16x the bit rate |
| bit_stb_o | output | 1 | One-cycle strobe at the bit rate |

## Verification
Four counts are used. The reset default 11 checks the 9600 bit/s period with no write at all. A count of 0 separates the prescaler period from the divisor period. A middle value of 5 is written with the upper data bits set, which shows those bits are dropped. The maximum count 63 exposes any width or wrap fault in the divisor. Rewrites issued in the middle of a period, including one that repeats the current value, show whether the reload clears all three phases or only some of them. In every cycle the behavioural edge-count model is compared against both strobes and against the read data.

// File: rtl/sir_baud_pkg.sv
package sir_baud_pkg;
  localparam int unsigned PRESC_DIV_DEF = 26;
  localparam int unsigned CNT_W_DEF     = 6;
  localparam int unsigned OVS_DEF       = 16;
  localparam int unsigned REG_W_DEF     = 16;
  localparam int unsigned RESET_CNT_DEF = 11;

  typedef struct packed {
    logic ovs;
    logic bitr;
  } baud_stb_t;
endpackage

// File: rtl/sir_baud_regs.sv
module sir_baud_regs #(
  parameter int unsigned REG_W     = 16,
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned RESET_CNT = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic             reload_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(RESET_CNT);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   count_q <= RST_VAL;
    else if (we_i) count_q <= wdata_i[CNT_W-1:0];
  end

  assign count_o  = count_q;
  assign reload_o = we_i;

  generate
    if (REG_W > CNT_W) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^wdata_i[REG_W-1:CNT_W];
      assign rdata_o   = {{(REG_W-CNT_W){1'b0}}, count_q};
    end else begin : g_full
      assign rdata_o = count_q;
    end
  endgenerate

  AST_WR_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o[CNT_W-1:0] == $past(wdata_i[CNT_W-1:0])); // R6
endmodule

// File: rtl/sir_prescaler.sv
module sir_prescaler #(
  parameter int unsigned DIV = 26
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reload_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (reload_i)      cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  AST_PRE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R2
  AST_PRE_SPARSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R3
endmodule

// File: rtl/sir_divisor.sv
module sir_divisor #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] div_q;
  logic             at_lim;

  assign at_lim = (div_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_q <= '0;
    else if (reload_i) div_q <= '0;
    else if (tick_i)   div_q <= at_lim ? '0 : div_q + 1'b1;
  end

  assign tick_o = tick_i & at_lim;

  AST_DIV_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q <= limit_i); // R2
  AST_DIV_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> tick_i); // R3
endmodule

// File: rtl/sir_bit_div.sv
module sir_bit_div #(
  parameter int unsigned OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reload_i,
  input  logic ovs_tick_i,
  output logic ovs_stb_o,
  output logic bit_stb_o
);
  localparam int unsigned W = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [W-1:0] LAST = W'(OVS - 1);

  logic [W-1:0] ph_q;
  logic         wrap;

  assign wrap = (ph_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= '0;
      ovs_stb_o <= 1'b0;
      bit_stb_o <= 1'b0;
    end else if (reload_i) begin
      ph_q      <= '0;
      ovs_stb_o <= 1'b0;
      bit_stb_o <= 1'b0;
    end else begin
      ovs_stb_o <= ovs_tick_i;
      bit_stb_o <= ovs_tick_i & wrap;
      if (ovs_tick_i) ph_q <= wrap ? '0 : ph_q + 1'b1;
    end
  end

  AST_BIT_WITH_OVS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |-> ovs_stb_o); // R4
  AST_OVS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovs_stb_o |=> !ovs_stb_o); // R2
endmodule

// File: rtl/sir_baud_gen.sv
module sir_baud_gen
  import sir_baud_pkg::*;
#(
  parameter int unsigned PRESC_DIV = PRESC_DIV_DEF,
  parameter int unsigned CNT_W     = CNT_W_DEF,
  parameter int unsigned OVS       = OVS_DEF,
  parameter int unsigned REG_W     = REG_W_DEF,
  parameter int unsigned RESET_CNT = RESET_CNT_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             ovs_stb_o,
  output logic             bit_stb_o
);
  logic [CNT_W-1:0] count;
  logic             reload;
  logic             pre_tick;
  logic             ovs_tick;
  baud_stb_t        stb;

  sir_baud_regs #(.REG_W(REG_W), .CNT_W(CNT_W), .RESET_CNT(RESET_CNT)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .count_o (count),
    .reload_o(reload),
    .rdata_o (reg_rdata_o)
  );

  sir_prescaler #(.DIV(PRESC_DIV)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .reload_i(reload),
    .tick_o  (pre_tick)
  );

  sir_divisor #(.CNT_W(CNT_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .reload_i(reload),
    .tick_i  (pre_tick),
    .limit_i (count),
    .tick_o  (ovs_tick)
  );

  sir_bit_div #(.OVS(OVS)) u_bit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .reload_i  (reload),
    .ovs_tick_i(ovs_tick),
    .ovs_stb_o (stb.ovs),
    .bit_stb_o (stb.bitr)
  );

  assign ovs_stb_o = stb.ovs;
  assign bit_stb_o = stb.bitr;

  AST_RELOAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> !ovs_stb_o && !bit_stb_o); // R5
endmodule

// File: tb/sir_baud_gen_tb.sv
module sir_baud_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ovs, bitr;

  int checks = 0;
  int errors = 0;
  int e = 0;
  int n = 11;
  bit chk_on = 1'b0;
  string cur_req = "R8";

  always #2 clk = ~clk;

  sir_baud_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .ovs_stb_o(ovs), .bit_stb_o(bitr)
  );

  // edge-count reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin e = 0; n = 11; end
    else if (we) begin e = 0; n = int'(wdata[5:0]); end
    else e = e + 1;
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && rst_n) begin
      int per;
      per = 26 * (n + 1);
      check(cur_req, "ovs_stb", int'(ovs), int'(e > 0 && e % per == 0));
      check("R4", "bit_stb", int'(bitr), int'(e > 0 && e % (per * 16) == 0));
      check("R6", "rdata", int'(rdata), n);
    end
  end

  task automatic run(int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] v);
    @(negedge clk);
    we = 1'b1; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=expired expected=done");
    finish_up();
  end

  initial begin
    run(3);
    check("R1", "ovs in reset", int'(ovs), 0);
    check("R1", "bit in reset", int'(bitr), 0);
    check("R1", "rdata in reset", int'(rdata), 16'h000B);
    rst_n = 1'b1;
    chk_on = 1'b1;
    cur_req = "R8";            // default 9600: bit period 4992
    run(2 * 4992 + 20);
    cur_req = "R3";            // count 0: every 26 cycles
    wr(16'h0000);
    run(26 * 16 * 3 + 7);
    cur_req = "R6";            // upper bits dropped, N=5
    wr(16'hFFC5);
    check("R6", "upper bits", int'(rdata[15:6]), 0);
    cur_req = "R2";
    run(26 * 6 * 16 * 2 + 11);
    cur_req = "R5";            // mid-period reloads
    run(97);
    wr(16'h0007);
    run(26 * 8 * 5 + 33);
    wr(16'h0007);              // same value again
    check("R5", "ovs after write", int'(ovs), 0);
    run(26 * 8 * 16 + 5);
    cur_req = "R7";            // max divisor
    wr(16'h003F);
    run(26624 * 2 + 30);
    chk_on = 1'b0;
    finish_up();
  end
endmodule